// File: doc/BRIEF.md
# Width-Doubling Synchronous FIFO

This block is a single-clock first-in first-out buffer whose write side takes one narrow word per cycle and whose read side hands out one word of twice that width per read, built from the two oldest narrow words. It serves a datapath that produces data at half the width a downstream consumer wants, packing pairs without any separate gearbox stage.

The buffer holds up to a parameterised number of narrow words. Its fill level, in narrow words, comes out on a port. Full and empty flags guard the two sides. A write while full and a read while empty are dropped without effect. Empty stays high until at least two narrow words are held, so every accepted read returns a complete wide word. A clock enable freezes all state when low. A synchronous clear, honoured only while enabled, empties the buffer. A parameter chooses between flags held in registers and flags decoded from the level. Both choices behave identically at the ports.

Top module: `widen_fifo`

## Requirements
- R1: While rst_n is low, level is 0, empty is 1 and full is 0.
- R2: An accepted write (wr_req high, full low, en high, clr low) raises level by one on the following clock edge.
- R3: While empty is low, rd_data shows the oldest stored pair: the older narrow word in bits [NW-1:0] and the next one in bits [2*NW-1:NW]. An accepted read (rd_req high, empty low) lowers level by two and moves on to the next pair.
- R4: empty is 1 exactly when level is below 2.
- R5: full is 1 exactly when level equals DEPTH. A write while full leaves level and rd_data unchanged.
- R6: A read while empty leaves level unchanged.
- R7: An accepted read and an accepted write in the same cycle lower level by one and keep word order.
- R8: While en is low, wr_req, rd_req and clr have no effect: level, flags and rd_data hold.
- R9: clr high with en high empties the buffer on the next edge (level 0, empty 1, full 0), whatever the other requests.
- R10: REG_FLAGS=1 (registered flags) and REG_FLAGS=0 (decoded flags) give the same empty, full, level and rd_data in every cycle.
- R11: Word order is kept across pointer wrap-around of the storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Clock enable; all state holds while low |
| clr | input | 1 | Synchronous clear, acts only while en is high |
| wr_req | input | 1 | Write request |
| wr_data | input | NW | Narrow write word |
| rd_req | input | 1 | Read request |
| rd_data | output | 2*NW | Wide read word, older word in the low half |
| empty | output | 1 | Fewer than two narrow words stored |
| full | output | 1 | DEPTH narrow words stored |
| level | output | LVL_W | Number of narrow words stored |

## Verification
The in-line assertions take for granted that en, clr, wr_req and rd_req are known after reset and change only between clock edges. They also assume that DEPTH is a power of two of at least four, which the elaboration checks enforce. The stimulus drives every input on the falling edge from one task and holds it through the next rising edge, so that rule is kept. It also deliberately issues requests against full and empty, because the design must tolerate such requests by dropping them.

// File: rtl/widen_fifo_pkg.sv
`timescale 1ns/1ps
package widen_fifo_pkg;

   // Bits needed for a count that runs from 0 up to and including n.
   function automatic int unsigned count_bits(input int unsigned n);
      return $clog2(n + 1);
   endfunction

   // Level change selected by {accepted read, accepted write}.
   typedef enum logic [1:0] {
      LV_IDLE = 2'b00,
      LV_PUSH = 2'b01,
      LV_POP  = 2'b10,
      LV_BOTH = 2'b11
   } lvl_op_e;

endpackage

// File: rtl/widen_fifo_ctrl.sv
`timescale 1ns/1ps
module widen_fifo_ctrl
   import widen_fifo_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned AW    = 4,
   parameter int unsigned LVL_W = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic             wr_req,
   input  logic             rd_req,
   input  logic             full,
   input  logic             empty,
   output logic             wr_ok,
   output logic [AW-1:0]    wr_ptr,
   output logic [AW-1:0]    rd_ptr,
   output logic [LVL_W-1:0] lvl,
   output logic [LVL_W-1:0] lvl_d
);

   logic    rd_ok;
   lvl_op_e op;

   assign wr_ok = en & ~clr & wr_req & ~full;
   assign rd_ok = en & ~clr & rd_req & ~empty;
   assign op    = lvl_op_e'({rd_ok, wr_ok});

   always_comb begin
      lvl_d = lvl;
      if (en) begin
         if (clr) begin
            lvl_d = '0;
         end else begin
            unique case (op)
               LV_PUSH: lvl_d = lvl + LVL_W'(1);
               LV_POP:  lvl_d = lvl - LVL_W'(2);
               LV_BOTH: lvl_d = lvl - LVL_W'(1);
               default: lvl_d = lvl;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         lvl    <= '0;
      end else begin
         lvl <= lvl_d;
         if (en && clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
         end else begin
            if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
            if (rd_ok) rd_ptr <= rd_ptr + AW'(2);
         end
      end
   end

   // R2
   lvl_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == LV_PUSH) |=> lvl == $past(lvl) + LVL_W'(1));
   // R7
   lvl_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == LV_BOTH) |=> lvl == $past(lvl) - LVL_W'(1));
   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(lvl) && $stable(wr_ptr) && $stable(rd_ptr));
   // R9
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && clr) |=> (lvl == '0) && (rd_ptr == '0));
   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl <= LVL_W'(DEPTH));
   // R3
   rd_pair_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ptr[0] == 1'b0);

endmodule

// File: rtl/widen_fifo_store.sv
`timescale 1ns/1ps
module widen_fifo_store #(
   parameter int unsigned NW    = 8,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned AW    = 4
)(
   input  logic            clk,
   input  logic            we,
   input  logic [AW-1:0]   wr_ptr,
   input  logic [NW-1:0]   wr_data,
   input  logic [AW-1:0]   rd_ptr,
   output logic [2*NW-1:0] rd_data
);

   localparam int unsigned PAIRS = DEPTH / 2;

   logic [NW-1:0] mem [DEPTH];
   logic [AW-1:0] lo_idx, hi_idx;

   always_ff @(posedge clk) begin
      if (we) mem[wr_ptr] <= wr_data;
   end

   // Pair slots are even-aligned: the older word sits on the even index.
   assign lo_idx  = {rd_ptr[AW-1:1], 1'b0};
   assign hi_idx  = {rd_ptr[AW-1:1], 1'b1};
   assign rd_data = {mem[hi_idx], mem[lo_idx]};

   initial begin
      assert (PAIRS * 2 == DEPTH) else $error("storage depth must be even");
   end

endmodule

// File: rtl/widen_fifo_flags.sv
`timescale 1ns/1ps
module widen_fifo_flags #(
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned LVL_W     = 5,
   parameter bit          REG_FLAGS = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] lvl,
   input  logic [LVL_W-1:0] lvl_d,
   output logic             full,
   output logic             empty
);

   localparam logic [LVL_W-1:0] LV_FULL = LVL_W'(DEPTH);
   localparam logic [LVL_W-1:0] LV_PAIR = LVL_W'(2);

   generate
      if (REG_FLAGS) begin : g_reg
         logic full_q, empty_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               full_q  <= 1'b0;
               empty_q <= 1'b1;
            end else begin
               full_q  <= (lvl_d == LV_FULL);
               empty_q <= (lvl_d < LV_PAIR);
            end
         end
         assign full  = full_q;
         assign empty = empty_q;
      end else begin : g_dec
         assign full  = (lvl == LV_FULL);
         assign empty = (lvl < LV_PAIR);
      end
   endgenerate

   // R4
   empty_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty == (lvl < LV_PAIR));
   // R5
   full_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full == (lvl == LV_FULL));
   // R10
   flag_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (empty == ($past(lvl_d) < LV_PAIR)) && (full == ($past(lvl_d) == LV_FULL)));
   // R4
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

endmodule

// File: rtl/widen_fifo.sv
`timescale 1ns/1ps
module widen_fifo
   import widen_fifo_pkg::*;
#(
   parameter int unsigned NW        = 8,
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned LVL_W     = count_bits(DEPTH),
   parameter bit          REG_FLAGS = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic             wr_req,
   input  logic [NW-1:0]    wr_data,
   input  logic             rd_req,
   output logic [2*NW-1:0]  rd_data,
   output logic             empty,
   output logic             full,
   output logic [LVL_W-1:0] level
);

   localparam int unsigned AW = $clog2(DEPTH);

   logic             wr_ok;
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [LVL_W-1:0] lvl, lvl_d;

   initial begin
      assert (DEPTH >= 4) else $error("DEPTH must be at least 4");
      assert ((1 << AW) == DEPTH) else $error("DEPTH must be a power of two");
      assert (LVL_W >= count_bits(DEPTH)) else $error("LVL_W too narrow for DEPTH");
      assert (NW >= 1) else $error("NW must be positive");
   end

   widen_fifo_ctrl #(
      .DEPTH (DEPTH),
      .AW    (AW),
      .LVL_W (LVL_W)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .clr    (clr),
      .wr_req (wr_req),
      .rd_req (rd_req),
      .full   (full),
      .empty  (empty),
      .wr_ok  (wr_ok),
      .wr_ptr (wr_ptr),
      .rd_ptr (rd_ptr),
      .lvl    (lvl),
      .lvl_d  (lvl_d)
   );

   widen_fifo_store #(
      .NW    (NW),
      .DEPTH (DEPTH),
      .AW    (AW)
   ) u_store (
      .clk     (clk),
      .we      (wr_ok),
      .wr_ptr  (wr_ptr),
      .wr_data (wr_data),
      .rd_ptr  (rd_ptr),
      .rd_data (rd_data)
   );

   widen_fifo_flags #(
      .DEPTH     (DEPTH),
      .LVL_W     (LVL_W),
      .REG_FLAGS (REG_FLAGS)
   ) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .lvl_d (lvl_d),
      .full  (full),
      .empty (empty)
   );

   assign level = lvl;

   // R6
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && empty && rd_req && !wr_req) |=> $stable(level));
   // R5
   full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && full && wr_req && !rd_req) |=> $stable(level));

endmodule

// File: tb/test_widen_fifo.sv
`timescale 1ns/1ps
module test_widen_fifo;

   localparam int NW = 8;
   localparam int DEPTH = 16;
   localparam int LW = 5;
   localparam int NV = 14;

   // {en, clr, wr, rd, wdata[8], lvl[5], empty, full, rdata[16]}
   localparam logic [34:0] VECS [NV] = '{
      {4'b1010, 8'h11, 5'd1, 1'b1, 1'b0, 16'h0000},
      {4'b1010, 8'h22, 5'd2, 1'b0, 1'b0, 16'h2211},
      {4'b1001, 8'h00, 5'd0, 1'b1, 1'b0, 16'h0000},
      {4'b1001, 8'h00, 5'd0, 1'b1, 1'b0, 16'h0000},
      {4'b1010, 8'h33, 5'd1, 1'b1, 1'b0, 16'h0000},
      {4'b1010, 8'h44, 5'd2, 1'b0, 1'b0, 16'h4433},
      {4'b1010, 8'h55, 5'd3, 1'b0, 1'b0, 16'h4433},
      {4'b1011, 8'h66, 5'd2, 1'b0, 1'b0, 16'h6655},
      {4'b0011, 8'h77, 5'd2, 1'b0, 1'b0, 16'h6655},
      {4'b0100, 8'h00, 5'd2, 1'b0, 1'b0, 16'h6655},
      {4'b1110, 8'h88, 5'd0, 1'b1, 1'b0, 16'h0000},
      {4'b1010, 8'h99, 5'd1, 1'b1, 1'b0, 16'h0000},
      {4'b1001, 8'h00, 5'd1, 1'b1, 1'b0, 16'h0000},
      {4'b1010, 8'hAA, 5'd2, 1'b0, 1'b0, 16'hAA99}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, clr = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [NW-1:0] wd = '0;
   logic [2*NW-1:0] rdat_a, rdat_b;
   logic emp_a, emp_b, ful_a, ful_b;
   logic [LW-1:0] lvl_a, lvl_b;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   widen_fifo #(.NW(NW), .DEPTH(DEPTH), .LVL_W(LW), .REG_FLAGS(1'b1)) i_widen_fifo (
      .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .wr_req(wr), .wr_data(wd),
      .rd_req(rd), .rd_data(rdat_a), .empty(emp_a), .full(ful_a), .level(lvl_a));

   widen_fifo #(.NW(NW), .DEPTH(DEPTH), .LVL_W(LW), .REG_FLAGS(1'b0)) i_widen_fifo_dec (
      .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .wr_req(wr), .wr_data(wd),
      .rd_req(rd), .rd_data(rdat_b), .empty(emp_b), .full(ful_b), .level(lvl_b));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // R10: both flag variants must agree at the ports
   task automatic cmp_modes();
      chk("R10 level", 32'(lvl_b), 32'(lvl_a));
      chk("R10 empty", 32'(emp_b), 32'(emp_a));
      chk("R10 full", 32'(ful_b), 32'(ful_a));
      if (!emp_a) chk("R10 rd_data", 32'(rdat_b), 32'(rdat_a));
   endtask

   // Drive at a falling edge, return at the next falling edge.
   task automatic cyc(input logic e, input logic c, input logic w, input logic r,
                      input logic [NW-1:0] d);
      en = e; clr = c; wr = w; rd = r; wd = d;
      @(negedge clk);
      en = 1'b1; clr = 1'b0; wr = 1'b0; rd = 1'b0;
      cmp_modes();
   endtask

   task automatic expect_state(input string tag, input int l, input logic e,
                               input logic f);
      chk({tag, " level"}, 32'(lvl_a), 32'(l));
      chk({tag, " empty"}, 32'(emp_a), 32'(e));
      chk({tag, " full"}, 32'(ful_a), 32'(f));
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [34:0] v;
      @(negedge clk);
      @(negedge clk);
      // R1: reset state
      expect_state("R1", 0, 1'b1, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table: R2 R3 R4 R6 R7 R8 R9
      for (int i = 0; i < NV; i++) begin
         v = VECS[i];
         cyc(v[34], v[33], v[32], v[31], v[30:23]);
         expect_state($sformatf("R2/R4/R6/R7/R8/R9 vec%0d", i),
                      int'(v[22:18]), v[17], v[16]);
         if (!v[17]) chk($sformatf("R3 vec%0d rd_data", i), 32'(rdat_a), 32'(v[15:0]));
      end

      // Fill to full
      cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'(8'h40 + i));
      expect_state("R5 fill", DEPTH, 1'b0, 1'b1);
      // R5: write while full ignored
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'hEE);
      expect_state("R5 write-full", DEPTH, 1'b0, 1'b1);
      chk("R5 rd_data after blocked write", 32'(rdat_a), 32'h4140);
      // R7/R5: read plus blocked write while full -> down by two
      cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'hEE);
      expect_state("R7 full rd+wr", DEPTH - 2, 1'b0, 1'b0);
      chk("R3 next pair", 32'(rdat_a), 32'h4342);
      // R11: refill across wrap
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'hF0);
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'hF1);
      expect_state("R11 refill", DEPTH, 1'b0, 1'b1);
      for (int p = 1; p < DEPTH / 2; p++) begin
         chk($sformatf("R11 pair%0d", p), 32'(rdat_a),
             32'({8'(8'h41 + 2 * p), 8'(8'h40 + 2 * p)}));
         cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
      end
      chk("R11 wrapped pair", 32'(rdat_a), 32'hF1F0);
      expect_state("R4 two left", 2, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
      expect_state("R4 drained", 0, 1'b1, 1'b0);

      // R1: asynchronous reset mid-run
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h12);
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h34);
      #2 rst_n = 1'b0;
      #1 expect_state("R1 async", 0, 1'b1, 1'b0);
      chk("R10 reset level", 32'(lvl_b), 32'(0));
      @(negedge clk);
      rst_n = 1'b1;
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h56);
      expect_state("R2 after reset", 1, 1'b1, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule